// File: doc/BRIEF.md
# Control Endpoint Receive Controller

This block makes the receive-side decisions for the default control endpoint of a USB device. A serial interface engine reports token arrivals (SETUP, OUT, IN) and data packet completions, each with its data PID, byte count and CRC verdict. For every data packet the block decides whether to answer with ACK, NAK or STALL, or to stay silent. It also tells the transmit side when an IN token may be served.

Software controls the block through a command register. That register holds a receive-enable bit, a halt bit, one ignore bit for each token type, and a self-clearing flush request. Software sees results through a read-only status byte whose flags clear when it is read. Two copies of the status are kept. When a zero-length packet has not yet been read and a SETUP with data follows it, the SETUP result waits in the second copy and appears on the read after the zero-length one. A SETUP that repeats an accepted SETUP, with no OUT or IN token in between, is acknowledged but otherwise thrown away. This lets the host recover from a lost handshake.

Top module: `ep0_rx_ctrl`

## Requirements
- R1: After reset, the command readback and the status byte are both zero, and no handshake or IN grant is issued.
- R2: A SETUP data packet with good CRC and a length of at most MAX_PKT is answered with ACK (hs_kind 0) one cycle after pkt_valid, even when receive-enable is clear. The status then shows count = length in bits 3:0, the last flag set in bit 4, the toggle in bit 5 (1 for DATA1) and the setup flag set in bit 6. Bit 7 always reads 0.
- R3: With receive-enable set (command bit 0), a good OUT data packet is answered with ACK and updates the status with its setup flag at 0. Any accepted data packet clears receive-enable.
- R4: A good OUT packet that arrives while receive-enable is clear and halt is clear is answered with NAK (hs_kind 1) and leaves the status unchanged.
- R5: While halt (command bit 4) is set, a good OUT packet is answered with STALL (hs_kind 2), leaves the status unchanged and clears receive-enable.
- R6: A SETUP packet that follows an accepted SETUP with no OUT or IN token in between is answered with ACK and leaves the status unchanged. An OUT or IN token ends this condition.
- R7: A packet with a bad CRC, or a SETUP longer than MAX_PKT, gets no handshake and does not change the status.
- R8: With ignore-OUT (bit 1) or ignore-SETUP (bit 2) set, that token's data packet gets no handshake and does not change the status. An IN token makes in_go pulse one cycle later unless ignore-IN (bit 3) is set. Token codes: 1 OUT, 2 IN, 3 SETUP, 0 no token.
- R9: An accepted zero-length packet sets the count to 0 and sets the last flag. The toggle and setup flags keep their previous values.
- R10: If a zero-length status is still unread when a SETUP with data is accepted, the first read returns the zero-length status and the second read returns the SETUP status.
- R11: Reading the status (stat_rd) clears the last, toggle and setup flags and keeps the count.
- R12: Writing 1 to command bit 7 requests a flush. The request reads back as 1 while it waits for a pending token's data packet. It then clears both status copies and the repeated-SETUP condition, and bit 7 reads 0 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tok_valid | input | 1 | Token received for this endpoint |
| tok_kind | input | 2 | Token type: 1 OUT, 2 IN, 3 SETUP |
| pkt_valid | input | 1 | Data packet finished |
| pkt_data1 | input | 1 | Packet used DATA1 PID |
| pkt_len | input | LEN_W | Packet payload length in bytes |
| pkt_crc_ok | input | 1 | Packet CRC was good |
| hs_valid | output | 1 | Send a handshake this cycle |
| hs_kind | output | 2 | Handshake: 0 ACK, 1 NAK, 2 STALL |
| in_go | output | 1 | IN token may be served |
| cmd_wr | input | 1 | Write strobe for the command register |
| cmd_wdata | input | 8 | Command write data |
| cmd_rdata | output | 8 | Command readback |
| stat_rd | input | 1 | Status read strobe (clear-on-read) |
| stat_rdata | output | 8 | Visible status byte |

## Verification
The bench builds the block with MAX_PKT = 8 and LEN_W = 4. With these values a length of 9 is both representable on the port and over the limit, so the oversize SETUP case can be reached. The maximum legal length of 8 exercises the top bit of the count field. The 4-bit length port also lets every count pass straight into the status count field without truncation.

// File: rtl/ep0_rx_pkg.sv
package ep0_rx_pkg;

    typedef enum logic [1:0] {
        TK_NONE  = 2'd0,
        TK_OUT   = 2'd1,
        TK_IN    = 2'd2,
        TK_SETUP = 2'd3
    } tok_e;

    typedef enum logic [1:0] {
        HS_ACK   = 2'd0,
        HS_NAK   = 2'd1,
        HS_STALL = 2'd2
    } hs_e;

    localparam int CNT_W = 4;

    typedef struct packed {
        logic halt;
        logic ign_in;
        logic ign_setup;
        logic ign_out;
        logic rx_en;
    } cmd_t;

    typedef struct packed {
        logic setup;
        logic toggle;
        logic last;
    } sflags_t;

    typedef struct packed {
        sflags_t           fl;
        logic [CNT_W-1:0]  cnt;
    } stat_t;

    function automatic logic tok_ignored(tok_e k, cmd_t c);
        case (k)
            TK_OUT:   return c.ign_out;
            TK_IN:    return c.ign_in;
            TK_SETUP: return c.ign_setup;
            default:  return 1'b1;
        endcase
    endfunction

    function automatic logic [7:0] stat_byte(stat_t s);
        return {1'b0, s.fl.setup, s.fl.toggle, s.fl.last, s.cnt};
    endfunction

endpackage

// File: rtl/ep0_cmd_reg.sv
module ep0_cmd_reg
    import ep0_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr,
    input  logic [7:0] wdata,
    input  logic       rx_en_clr,
    input  logic       busy,
    output cmd_t       cmd,
    output logic       flush_now,
    output logic [7:0] rdata
);
    logic flush_req;

    assign flush_now = flush_req && !busy;
    assign rdata     = {flush_req, 2'b00, cmd.halt, cmd.ign_in,
                        cmd.ign_setup, cmd.ign_out, cmd.rx_en};

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd       <= '0;
            flush_req <= 1'b0;
        end else begin
            if (flush_now)
                flush_req <= 1'b0;
            if (wr) begin
                cmd.rx_en     <= wdata[0];
                cmd.ign_out   <= wdata[1];
                cmd.ign_setup <= wdata[2];
                cmd.ign_in    <= wdata[3];
                cmd.halt      <= wdata[4];
                if (wdata[7])
                    flush_req <= 1'b1;
            end else if (rx_en_clr) begin
                cmd.rx_en <= 1'b0;
            end
        end
    end

    p_rxen_clear_r3: assert property (@(posedge clk) disable iff (rst)
        (rx_en_clr && !wr) |=> !cmd.rx_en);

    p_flush_wait_r12: assert property (@(posedge clk) disable iff (rst)
        (flush_req && busy && !wr) |=> flush_req);

endmodule

// File: rtl/ep0_rx_decide.sv
module ep0_rx_decide
    import ep0_rx_pkg::*;
#(
    parameter int MAX_PKT = 8,
    parameter int LEN_W   = 4
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             tok_valid,
    input  logic [1:0]       tok_kind,
    input  logic             pkt_valid,
    input  logic             pkt_data1,
    input  logic [LEN_W-1:0] pkt_len,
    input  logic             pkt_crc_ok,
    input  cmd_t             cmd,
    input  logic             flush_now,
    output logic             hs_valid,
    output logic [1:0]       hs_kind,
    output logic             in_go,
    output logic             rx_en_clr,
    output logic             busy,
    output logic             upd_valid,
    output logic             upd_zlp,
    output logic             upd_setup,
    output logic             upd_data1,
    output logic [CNT_W-1:0] upd_len
);
    localparam logic [LEN_W-1:0] MAX_LEN = LEN_W'(MAX_PKT);

    tok_e pend_kind;
    logic pend_v;
    logic pend_ign;
    logic chain;

    tok_e tk_in;
    logic active;
    logic len_ok;
    logic d_hs;
    hs_e  d_kind;
    logic d_chain_set;

    assign tk_in  = tok_e'(tok_kind);
    assign busy   = pend_v;
    assign len_ok = (pkt_len <= MAX_LEN);
    assign active = pkt_valid && pend_v && !pend_ign && pkt_crc_ok;

    always_comb begin
        d_hs        = 1'b0;
        d_kind      = HS_ACK;
        d_chain_set = 1'b0;
        upd_valid   = 1'b0;
        rx_en_clr   = 1'b0;
        if (active) begin
            if (pend_kind == TK_SETUP) begin
                if (chain) begin
                    d_hs = 1'b1;
                end else if (len_ok) begin
                    d_hs        = 1'b1;
                    upd_valid   = 1'b1;
                    rx_en_clr   = 1'b1;
                    d_chain_set = 1'b1;
                end
            end else if (pend_kind == TK_OUT) begin
                d_hs = 1'b1;
                if (cmd.halt) begin
                    d_kind    = HS_STALL;
                    rx_en_clr = 1'b1;
                end else if (!cmd.rx_en || !len_ok) begin
                    d_kind = HS_NAK;
                end else begin
                    upd_valid = 1'b1;
                    rx_en_clr = 1'b1;
                end
            end
        end
    end

    assign upd_zlp   = (pkt_len == '0);
    assign upd_setup = (pend_kind == TK_SETUP);
    assign upd_data1 = pkt_data1;
    assign upd_len   = CNT_W'(pkt_len);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_v    <= 1'b0;
            pend_kind <= TK_NONE;
            pend_ign  <= 1'b0;
            chain     <= 1'b0;
            hs_valid  <= 1'b0;
            hs_kind   <= 2'd0;
            in_go     <= 1'b0;
        end else begin
            hs_valid <= d_hs;
            hs_kind  <= d_kind;
            in_go    <= 1'b0;
            if (pkt_valid)
                pend_v <= 1'b0;
            if (d_chain_set)
                chain <= 1'b1;
            if (tok_valid && tk_in != TK_NONE) begin
                if (tk_in == TK_IN) begin
                    in_go <= !cmd.ign_in;
                    chain <= 1'b0;
                end else begin
                    pend_v    <= 1'b1;
                    pend_kind <= tk_in;
                    pend_ign  <= tok_ignored(tk_in, cmd);
                    if (tk_in == TK_OUT)
                        chain <= 1'b0;
                end
            end
            if (flush_now)
                chain <= 1'b0;
        end
    end

    p_hs_follows_pkt_r2: assert property (@(posedge clk) disable iff (rst)
        hs_valid |-> $past(pkt_valid));

    p_nak_only_out_r4: assert property (@(posedge clk) disable iff (rst)
        (hs_valid && hs_kind == HS_NAK) |-> $past(pend_kind == TK_OUT));

    p_stall_needs_halt_r5: assert property (@(posedge clk) disable iff (rst)
        (hs_valid && hs_kind == HS_STALL) |-> $past(cmd.halt));

    p_no_hs_bad_crc_r7: assert property (@(posedge clk) disable iff (rst)
        (pkt_valid && !pkt_crc_ok) |=> !hs_valid);

    p_dup_no_update_r6: assert property (@(posedge clk) disable iff (rst)
        (pkt_valid && chain && pend_kind == TK_SETUP) |-> !upd_valid);

endmodule

// File: rtl/ep0_stat_buf.sv
module ep0_stat_buf
    import ep0_rx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             upd_valid,
    input  logic             upd_zlp,
    input  logic             upd_setup,
    input  logic             upd_data1,
    input  logic [CNT_W-1:0] upd_len,
    input  logic             rd,
    input  logic             flush,
    output logic [7:0]       rdata
);
    stat_t m_q, m_d;
    stat_t b_q, b_d;
    logic  m_zlp_q, m_zlp_d;
    logic  b_v_q, b_v_d;

    assign rdata = stat_byte(m_q);

    always_comb begin
        m_d     = m_q;
        b_d     = b_q;
        m_zlp_d = m_zlp_q;
        b_v_d   = b_v_q;
        if (rd) begin
            m_zlp_d = 1'b0;
            if (b_v_q) begin
                m_d   = b_q;
                b_v_d = 1'b0;
            end else begin
                m_d.fl = '0;
            end
        end
        if (upd_valid) begin
            if (upd_zlp) begin
                m_d.cnt     = '0;
                m_d.fl.last = 1'b1;
                m_zlp_d     = 1'b1;
            end else if (upd_setup && m_zlp_q && !rd) begin
                b_d.cnt       = upd_len;
                b_d.fl.last   = 1'b1;
                b_d.fl.toggle = upd_data1;
                b_d.fl.setup  = 1'b1;
                b_v_d         = 1'b1;
            end else begin
                m_d.cnt       = upd_len;
                m_d.fl.last   = 1'b1;
                m_d.fl.toggle = upd_data1;
                m_d.fl.setup  = upd_setup;
                m_zlp_d       = 1'b0;
            end
        end
        if (flush) begin
            m_d     = '0;
            b_d     = '0;
            m_zlp_d = 1'b0;
            b_v_d   = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            m_q     <= '0;
            b_q     <= '0;
            m_zlp_q <= 1'b0;
            b_v_q   <= 1'b0;
        end else begin
            m_q     <= m_d;
            b_q     <= b_d;
            m_zlp_q <= m_zlp_d;
            b_v_q   <= b_v_d;
        end
    end

    p_second_copy_setup_r10: assert property (@(posedge clk) disable iff (rst)
        (rd && b_v_q && !upd_valid && !flush) |=> rdata[6]);

    p_read_clears_r11: assert property (@(posedge clk) disable iff (rst)
        (rd && !b_v_q && !upd_valid && !flush) |=> (rdata[6:4] == 3'b000));

    p_flush_empties_r12: assert property (@(posedge clk) disable iff (rst)
        flush |=> (rdata == 8'h00 && !b_v_q));

    p_reserved_bit_r2: assert property (@(posedge clk) disable iff (rst)
        !rdata[7]);

endmodule

// File: rtl/ep0_rx_ctrl.sv
module ep0_rx_ctrl
    import ep0_rx_pkg::*;
#(
    parameter int MAX_PKT = 8,
    parameter int LEN_W   = 4
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             tok_valid,
    input  logic [1:0]       tok_kind,
    input  logic             pkt_valid,
    input  logic             pkt_data1,
    input  logic [LEN_W-1:0] pkt_len,
    input  logic             pkt_crc_ok,
    output logic             hs_valid,
    output logic [1:0]       hs_kind,
    output logic             in_go,
    input  logic             cmd_wr,
    input  logic [7:0]       cmd_wdata,
    output logic [7:0]       cmd_rdata,
    input  logic             stat_rd,
    output logic [7:0]       stat_rdata
);
    cmd_t             cmd;
    logic             flush_now;
    logic             rx_en_clr;
    logic             busy;
    logic             upd_valid, upd_zlp, upd_setup, upd_data1;
    logic [CNT_W-1:0] upd_len;

    initial begin
        assert (MAX_PKT < (1 << CNT_W) && MAX_PKT < (1 << LEN_W));
    end

    ep0_cmd_reg u_cmd (
        .clk       (clk),
        .rst       (rst),
        .wr        (cmd_wr),
        .wdata     (cmd_wdata),
        .rx_en_clr (rx_en_clr),
        .busy      (busy),
        .cmd       (cmd),
        .flush_now (flush_now),
        .rdata     (cmd_rdata)
    );

    ep0_rx_decide #(.MAX_PKT(MAX_PKT), .LEN_W(LEN_W)) u_dec (
        .clk        (clk),
        .rst        (rst),
        .tok_valid  (tok_valid),
        .tok_kind   (tok_kind),
        .pkt_valid  (pkt_valid),
        .pkt_data1  (pkt_data1),
        .pkt_len    (pkt_len),
        .pkt_crc_ok (pkt_crc_ok),
        .cmd        (cmd),
        .flush_now  (flush_now),
        .hs_valid   (hs_valid),
        .hs_kind    (hs_kind),
        .in_go      (in_go),
        .rx_en_clr  (rx_en_clr),
        .busy       (busy),
        .upd_valid  (upd_valid),
        .upd_zlp    (upd_zlp),
        .upd_setup  (upd_setup),
        .upd_data1  (upd_data1),
        .upd_len    (upd_len)
    );

    ep0_stat_buf u_stat (
        .clk       (clk),
        .rst       (rst),
        .upd_valid (upd_valid),
        .upd_zlp   (upd_zlp),
        .upd_setup (upd_setup),
        .upd_data1 (upd_data1),
        .upd_len   (upd_len),
        .rd        (stat_rd),
        .flush     (flush_now),
        .rdata     (stat_rdata)
    );

    p_in_grant_r8: assert property (@(posedge clk) disable iff (rst)
        in_go |-> $past(tok_valid && tok_kind == 2'd2 && !cmd_rdata[3]));

endmodule

// File: tb/ep0_rx_ctrl_bench.sv
`timescale 1ns/1ps
module ep0_rx_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tok_valid = 0, pkt_valid = 0, pkt_data1 = 0, pkt_crc_ok = 0;
    logic [1:0] tok_kind = 0;
    logic [3:0] pkt_len = 0;
    logic       hs_valid, in_go;
    logic [1:0] hs_kind;
    logic       cmd_wr = 0, stat_rd = 0;
    logic [7:0] cmd_wdata = 0, cmd_rdata, stat_rdata;

    int total = 0;
    int bad   = 0;
    logic       got_hv;
    logic [1:0] got_hk;
    logic [7:0] rv;

    always #2.5 clk = ~clk;

    ep0_rx_ctrl #(.MAX_PKT(8), .LEN_W(4)) u_ep0_rx_ctrl (
        .clk(clk), .rst(rst), .tok_valid(tok_valid), .tok_kind(tok_kind),
        .pkt_valid(pkt_valid), .pkt_data1(pkt_data1), .pkt_len(pkt_len),
        .pkt_crc_ok(pkt_crc_ok), .hs_valid(hs_valid), .hs_kind(hs_kind),
        .in_go(in_go), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
        .cmd_rdata(cmd_rdata), .stat_rd(stat_rd), .stat_rdata(stat_rdata)
    );

    typedef struct packed {
        logic [7:0] cmd;
        logic [1:0] tok;
        logic [3:0] len;
        logic       d1;
        logic       crc;
        logic       ehv;
        logic [1:0] ehk;
        logic [7:0] est;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VEC [NV] = '{
        '{8'h00, 2'd3, 4'd8, 1'b0, 1'b1, 1'b1, 2'd0, 8'h58}, // R2
        '{8'h01, 2'd1, 4'd5, 1'b1, 1'b1, 1'b1, 2'd0, 8'h35}, // R3
        '{8'h00, 2'd1, 4'd3, 1'b0, 1'b1, 1'b1, 2'd1, 8'h00}, // R4
        '{8'h11, 2'd1, 4'd2, 1'b0, 1'b1, 1'b1, 2'd2, 8'h00}, // R5
        '{8'h00, 2'd3, 4'd8, 1'b0, 1'b0, 1'b0, 2'd0, 8'h00}, // R7
        '{8'h00, 2'd3, 4'd9, 1'b0, 1'b1, 1'b0, 2'd0, 8'h00}, // R7
        '{8'h04, 2'd3, 4'd8, 1'b0, 1'b1, 1'b0, 2'd0, 8'h00}, // R8
        '{8'h03, 2'd1, 4'd4, 1'b0, 1'b1, 1'b0, 2'd0, 8'h00}, // R8
        '{8'h01, 2'd1, 4'd0, 1'b1, 1'b1, 1'b1, 2'd0, 8'h10}  // R9
    };
    localparam string VTAG [NV] = '{"R2","R3","R4","R5","R7","R7","R8","R8","R9"};

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic wr_cmd(input logic [7:0] v);
        cmd_wr = 1'b1; cmd_wdata = v;
        cyc();
        cmd_wr = 1'b0;
    endtask

    task automatic flush();
        wr_cmd(8'h80);
        cyc();
    endtask

    task automatic tok(input logic [1:0] k);
        tok_valid = 1'b1; tok_kind = k;
        cyc();
        tok_valid = 1'b0;
    endtask

    task automatic pkt(input logic [3:0] len, input logic d1, input logic crc);
        pkt_valid = 1'b1; pkt_len = len; pkt_data1 = d1; pkt_crc_ok = crc;
        cyc();
        pkt_valid = 1'b0;
        got_hv = hs_valid;
        got_hk = hs_kind;
    endtask

    task automatic rd_stat(output logic [7:0] v);
        v = stat_rdata;
        stat_rd = 1'b1;
        cyc();
        stat_rd = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        total++; bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) cyc();
        rst = 1'b0;
        cyc();
        // R1 reset state
        check("R1 cmd", cmd_rdata, 0);
        check("R1 stat", stat_rdata, 0);
        check("R1 hs", hs_valid, 0);
        check("R1 in_go", in_go, 0);

        for (int i = 0; i < NV; i++) begin
            flush();
            wr_cmd(VEC[i].cmd);
            tok(VEC[i].tok);
            pkt(VEC[i].len, VEC[i].d1, VEC[i].crc);
            check({VTAG[i], " hs_valid"}, got_hv, VEC[i].ehv);
            if (VEC[i].ehv)
                check({VTAG[i], " hs_kind"}, got_hk, VEC[i].ehk);
            rd_stat(rv);
            check({VTAG[i], " status"}, rv, VEC[i].est);
        end

        // R3 receive-enable clears after accepted OUT; R5 after STALL
        flush(); wr_cmd(8'h01); tok(2'd1); pkt(4'd1, 1'b0, 1'b1);
        check("R3 rx_en cleared", cmd_rdata, 8'h00);
        wr_cmd(8'h11); tok(2'd1); pkt(4'd1, 1'b0, 1'b1);
        check("R5 rx_en cleared", cmd_rdata, 8'h10);

        // R6 repeated SETUP acked and dropped
        flush(); wr_cmd(8'h00);
        tok(2'd3); pkt(4'd8, 1'b0, 1'b1);
        tok(2'd3); pkt(4'd4, 1'b1, 1'b1);
        check("R6 dup ack", {got_hv, got_hk}, 3'b100);
        rd_stat(rv);
        check("R6 dup no update", rv, 8'h58);
        tok(2'd1); pkt(4'd2, 1'b0, 1'b1);
        check("R4 nak", {got_hv, got_hk}, 3'b101);
        tok(2'd3); pkt(4'd8, 1'b1, 1'b1);
        rd_stat(rv);
        check("R6 chain ended by OUT", rv, 8'h78);
        // R11 clear on read keeps count
        rd_stat(rv);
        check("R11 flags cleared", rv, 8'h08);

        // R9 / R10 zero-length then SETUP
        flush(); wr_cmd(8'h01);
        tok(2'd1); pkt(4'd2, 1'b1, 1'b1);
        wr_cmd(8'h01);
        tok(2'd1); pkt(4'd0, 1'b0, 1'b1);
        tok(2'd3); pkt(4'd8, 1'b0, 1'b1);
        check("R10 setup ack", {got_hv, got_hk}, 3'b100);
        rd_stat(rv);
        check("R10 first read zlp (R9 toggle kept)", rv, 8'h30);
        rd_stat(rv);
        check("R10 second read setup", rv, 8'h58);
        rd_stat(rv);
        check("R11 after two reads", rv, 8'h08);

        // R8 IN grant and ignore
        flush(); wr_cmd(8'h00);
        tok(2'd2);
        check("R8 in_go", in_go, 1);
        wr_cmd(8'h08);
        tok(2'd2);
        check("R8 in ignored", in_go, 0);

        // R12 deferred flush
        flush(); wr_cmd(8'h00);
        tok(2'd3);
        wr_cmd(8'h80);
        check("R12 flush pending", cmd_rdata[7], 1);
        pkt(4'd8, 1'b0, 1'b1);
        check("R12 packet acked", {got_hv, got_hk}, 3'b100);
        cyc();
        check("R12 flush done", cmd_rdata[7], 0);
        check("R12 status cleared", stat_rdata, 8'h00);
        tok(2'd3); pkt(4'd3, 1'b1, 1'b1);
        rd_stat(rv);
        check("R12 chain cleared", rv, 8'h73);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule